// File: doc/BRIEF.md
# Double-Rate Input Capture with Selectable Edge Alignment

This block takes an input bit that carries data on both clock edges and splits it into two single-rate outputs. `qa` carries the bit sampled on the rising edge. `qb` carries the bit sampled on the falling edge. A bit pair is the bit sampled on a rising edge together with the bit sampled on the falling edge that follows it.

A two-bit mode input selects where the falling-edge bit is presented and how the two bits line up. In the raw mode each output moves on its own edge. In the retimed mode both outputs move on the rising edge, but `qb` trails the `qa` bit of its pair by one cycle. In the paired mode `qa` is held back one extra cycle, so both bits of a pair appear together on the same rising edge. A `valid` flag tells downstream logic when the pipeline for the chosen mode holds captured data and no longer holds reset values.

Top module: `ddr_in_align`

## Requirements
- R1: In modes 2'b00 and 2'b01, `qa` changes only on the rising edge and shows the `din` value sampled at the most recent rising edge.
- R2: In mode 2'b00, `qb` shows the `din` value sampled at the most recent falling edge, so it changes half a cycle after `qa`.
- R3: In mode 2'b01, `qb` changes only on rising edges. After rising edge n it holds the falling-edge bit taken between edges n-1 and n. That is one cycle after `qa` showed the rising bit of the same pair.
- R4: In mode 2'b10, after rising edge n `qa` holds the rising bit from edge n-1 and `qb` holds the falling bit of that same pair. Neither output changes on a falling edge.
- R5: Mode 2'b11 behaves exactly like mode 2'b10.
- R6: While the synchronous active-high `rst` is sampled high, every register clears: `qa`, `qb` and `valid` read 0 after the next edge of their own clock phase.
- R7: After `rst` is released, `valid` is low until the pipeline fills. In mode 2'b00 it rises after the first rising edge. In modes 2'b01, 2'b10 and 2'b11 it rises after the second rising edge. It then stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Alignment select: 00 raw, 01 retimed, 10/11 paired |
| din | input | WIDTH | Double-rate input data |
| qa | output | WIDTH | Rising-edge bit of a pair |
| qb | output | WIDTH | Falling-edge bit of a pair |
| valid | output | 1 | Pipeline filled for the selected mode |

## Verification
Each output is due at a different delay after its input bit. In raw mode, `qa` is due one rising edge after the rising bit and `qb` one falling edge after the falling bit. In retimed mode, `qb` arrives on the rising edge that follows its falling bit. In paired mode, both bits of pair n appear at rising edge n+1, and `valid` follows the 1-or-2-edge fill count. The bench changes `din` 5 ns after each edge and samples 5 ns after the next edge. After a rising edge it checks `qa`, `qb` and `valid`. After a falling edge it checks that `qb` has moved in raw mode and has held still in every other mode. Expected bits come from arithmetic functions of the pair index.

// File: rtl/ddr_cap_pkg.sv
package ddr_cap_pkg;

    typedef enum logic [1:0] {
        ALIGN_RAW     = 2'b00,
        ALIGN_RETIME  = 2'b01,
        ALIGN_PAIRED  = 2'b10,
        ALIGN_PAIRED2 = 2'b11
    } align_mode_e;

    localparam int unsigned FILL_W = 2;

    // Rising edges after reset before the selected mode's outputs hold real data.
    function automatic logic [FILL_W-1:0] fill_need(input align_mode_e m);
        return (m == ALIGN_RAW) ? FILL_W'(1) : FILL_W'(2);
    endfunction

endpackage

// File: rtl/ddr_fall_stage.sv
module ddr_fall_stage #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] fall_o
);

    typedef struct packed {
        logic [WIDTH-1:0] cap;
    } fall_state_t;

    fall_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            st_d.cap = din;
        end
    end

    always_ff @(negedge clk) begin
        st_q <= st_d;
    end

    assign fall_o = st_q.cap;

endmodule

// File: rtl/ddr_rise_stage.sv
module ddr_rise_stage
    import ddr_cap_pkg::*;
#(
    parameter int unsigned WIDTH = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WIDTH-1:0]  din,
    input  logic [WIDTH-1:0]  fall_i,
    output logic [WIDTH-1:0]  rise_o,
    output logic [WIDTH-1:0]  rise_dly_o,
    output logic [WIDTH-1:0]  fall_rt_o,
    output logic [FILL_W-1:0] fill_o
);

    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(2);

    typedef struct packed {
        logic [WIDTH-1:0]  rise_cap;
        logic [WIDTH-1:0]  rise_dly;
        logic [WIDTH-1:0]  fall_rt;
        logic [FILL_W-1:0] fill;
    } rise_state_t;

    rise_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            st_d.rise_cap = din;
            st_d.rise_dly = st_q.rise_cap;
            st_d.fall_rt  = fall_i;
            if (st_q.fill != FILL_MAX) begin
                st_d.fill = st_q.fill + FILL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rise_o     = st_q.rise_cap;
    assign rise_dly_o = st_q.rise_dly;
    assign fall_rt_o  = st_q.fall_rt;
    assign fill_o     = st_q.fill;

    // R7: the fill count saturates and never passes its limit
    p_fill_saturates_r7: assert property (@(posedge clk) disable iff (rst)
        (fill_o == FILL_MAX) |=> (fill_o == FILL_MAX));

endmodule

// File: rtl/ddr_out_select.sv
module ddr_out_select
    import ddr_cap_pkg::*;
#(
    parameter int unsigned WIDTH = 1
) (
    input  logic [1:0]        mode,
    input  logic [WIDTH-1:0]  rise_i,
    input  logic [WIDTH-1:0]  rise_dly_i,
    input  logic [WIDTH-1:0]  fall_i,
    input  logic [WIDTH-1:0]  fall_rt_i,
    input  logic [FILL_W-1:0] fill_i,
    output logic [WIDTH-1:0]  qa,
    output logic [WIDTH-1:0]  qb,
    output logic              valid
);

    align_mode_e sel;

    always_comb begin
        sel = align_mode_e'(mode);
        case (sel)
            ALIGN_RAW: begin
                qa = rise_i;
                qb = fall_i;
            end
            ALIGN_RETIME: begin
                qa = rise_i;
                qb = fall_rt_i;
            end
            default: begin
                qa = rise_dly_i;
                qb = fall_rt_i;
            end
        endcase
        valid = (fill_i >= fill_need(sel));
    end

endmodule

// File: rtl/ddr_in_align.sv
module ddr_in_align
    import ddr_cap_pkg::*;
#(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] qa,
    output logic [WIDTH-1:0] qb,
    output logic             valid
);

    logic [WIDTH-1:0]  fall_w;
    logic [WIDTH-1:0]  rise_w;
    logic [WIDTH-1:0]  rise_dly_w;
    logic [WIDTH-1:0]  fall_rt_w;
    logic [FILL_W-1:0] fill_w;

    ddr_fall_stage #(.WIDTH(WIDTH)) u_fall (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .fall_o (fall_w)
    );

    ddr_rise_stage #(.WIDTH(WIDTH)) u_rise (
        .clk        (clk),
        .rst        (rst),
        .din        (din),
        .fall_i     (fall_w),
        .rise_o     (rise_w),
        .rise_dly_o (rise_dly_w),
        .fall_rt_o  (fall_rt_w),
        .fill_o     (fill_w)
    );

    ddr_out_select #(.WIDTH(WIDTH)) u_sel (
        .mode       (mode),
        .rise_i     (rise_w),
        .rise_dly_i (rise_dly_w),
        .fall_i     (fall_w),
        .fall_rt_i  (fall_rt_w),
        .fill_i     (fill_w),
        .qa         (qa),
        .qb         (qb),
        .valid      (valid)
    );

    // R6: reset clears the rising-phase outputs
    p_reset_clears_r6: assert property (@(posedge clk)
        rst |=> (qa == '0 && !valid));

    // R1: in raw and retimed modes qa is the previous rising-edge sample
    p_rise_capture_r1: assert property (@(posedge clk) disable iff (rst)
        (!mode[1] && !$past(rst)) |-> (qa == $past(din)));

    // R2: in raw mode qb is the previous falling-edge sample
    p_fall_capture_r2: assert property (@(negedge clk) disable iff (rst)
        (mode == 2'b00 && !$past(rst)) |-> (qb == $past(din)));

    // R3, R4, R5: outside raw mode qb carries the falling sample into the rising phase
    p_retimed_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b00 && !$past(rst)) |-> (qb == $past(fall_w)));

    // R4, R5: paired modes delay qa by one extra rising edge
    p_paired_qa_r4: assert property (@(posedge clk) disable iff (rst)
        (mode[1] && !$past(rst) && !$past(rst, 2)) |-> (qa == $past(din, 2)));

    // R7: valid is low on the first edge after reset and high once two edges have passed
    p_valid_low_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !valid);
    p_valid_full_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> valid);

endmodule

// File: tb/test_ddr_in_align.sv
`timescale 1ns/1ps
module test_ddr_in_align;

    localparam int NPAIRS = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic [0:0] din = 1'b0;
    logic [0:0] qa;
    logic [0:0] qb;
    logic       valid;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    ddr_in_align #(.WIDTH(1)) i_ddr_in_align (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .din   (din),
        .qa    (qa),
        .qb    (qb),
        .valid (valid)
    );

    // Pattern bits for pair k; negative k stands for the cleared state
    function automatic logic rbit(input int k);
        if (k < 0) return 1'b0;
        return logic'(((k >> 1) ^ k ^ (k >> 3)) & 1);
    endfunction

    function automatic logic fbit(input int k);
        if (k < 0) return 1'b0;
        return logic'((~(k ^ (k >> 2))) & 1);
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s mode=%0d actual=%b expected=%b at %0t", req, what, mode, act, exp, $time);
        end
    endtask

    task automatic run_mode(input logic [1:0] m);
        string rq;
        rq = (m == 2'b00) ? "R2" : (m == 2'b01) ? "R3" : (m == 2'b10) ? "R4" : "R5";
        rst  = 1'b1;
        mode = m;
        din  = 1'b1;
        repeat (3) @(posedge clk);
        #5;
        chk("R6", "qa in reset", qa[0], 1'b0);
        chk("R6", "valid in reset", valid, 1'b0);
        @(negedge clk);
        #5;
        chk("R6", "qb in reset", qb[0], 1'b0);
        rst = 1'b0;
        for (int c = 0; c < NPAIRS; c++) begin
            din = rbit(c);
            @(posedge clk);
            #5;
            if (m[1]) begin
                chk(rq, "qa paired", qa[0], rbit(c - 1));
            end else begin
                chk("R1", "qa rising", qa[0], rbit(c));
            end
            chk(rq, "qb at rising", qb[0], fbit(c - 1));
            if (m == 2'b00) chk("R7", "valid raw", valid, 1'b1);
            else            chk("R7", "valid fill", valid, (c >= 1));
            din = fbit(c);
            @(negedge clk);
            #5;
            if (m == 2'b00) chk("R2", "qb falling", qb[0], fbit(c));
            else            chk(rq, "qb held on falling", qb[0], fbit(c - 1));
        end
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int m = 0; m < 4; m++) begin
            run_mode(2'(m));
        end
        // back to the raw mode after paired runs, with a fresh reset
        run_mode(2'b00);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule